// File: doc/BRIEF.md
# Direct-Mapped Write-Back Second-Level Cache Controller

This block sits between a 32-bit processor bus and a main-memory burst port. It caches whole 16-byte lines of four 32-bit words in a direct-mapped array. Every processor access is a line burst of four words. The controller reads the tag and word 0 of the indexed line in the accept cycle and compares the tag in the next cycle. A hit is served from the local array with 2-1-1-1 timing. A miss goes to main memory.

The `wb_mode` input selects the write policy. In write-through mode all 8 stored tag bits are compared and every write reaches memory. In write-back mode the top stored tag bit is a dirty flag. Only 7 tag bits are compared, which halves the cacheable range. Write hits then stay in the cache. A read miss on a dirty line first writes the old line back, then refills it. Each refill word is handed to the processor in the same cycle that it is written into the array.

Write misses always bypass the cache, and addresses outside the cacheable range always go to memory without allocation. `wb_mode` is expected to stay constant between resets.

With the defaults (`IDX_W`=6, `TAG_W`=8) the index is address bits [9:4] and the tag is bits [17:10]. With `IDX_W`=14 these become [17:4] and [25:18], which gives 16K lines and 256KB of data.

Top module: `l2_wb_ctrl`

## Requirements
- R1: After reset `cpu_rdy` and `mem_req` are low and every line is invalid, so the first read of any address is a miss.
- R2: A read hit returns the four cached words in ascending order. `cpu_rdy` is high exactly in the 2nd, 3rd, 4th and 5th cycles, counting the cycle in which the idle controller samples `cpu_req` as the 1st. No memory request is made.
- R3: A cacheable read miss on a clean or invalid line fetches the line from memory. Each word is returned on `cpu_rdy` in the cycle of its `mem_ack`. The line is then valid, so the next read of the same address hits.
- R4: In write-through mode (`wb_mode`=0) a write hit writes the four words to memory, with one `cpu_rdy` per `mem_ack`. It also updates the cached line.
- R5: A write miss writes the four words to memory and leaves the cache unchanged. The line previously held at that index still hits with its old data, and no write-back occurs.
- R6: In write-back mode (`wb_mode`=1) a write hit updates only the cache, with R2 timing and no memory request, and marks the line dirty.
- R7: In write-back mode, a read miss on a valid dirty line first writes its four words back to the old line address in ascending order. `cpu_rdy` stays low during these writes. The fill of R3 follows.
- R8: An address is cacheable only when bits [31:TAG_W+IDX_W+4] are zero; in write-back mode bit TAG_W+IDX_W+3 (bit 17 by default) must also be zero. Any other address always misses, goes to memory and is never allocated.
- R9: The line index is address bits [IDX_W+3:4] and the tag is the next TAG_W bits. Two addresses with the same index and different tags evict each other.
- R10: Once raised, `mem_req` stays high with stable `mem_addr` until acknowledged. A memory burst covers `line base + 4*beat` for beats 0 to 3 in order, and `mem_req` drops after the fourth ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back policy, 0 = write-through |
| cpu_req | input | 1 | Access request, held until the fourth `cpu_rdy` |
| cpu_we | input | 1 | 1 = write burst, 0 = read burst |
| cpu_addr | input | 28 | Line address, byte address bits [31:4] |
| cpu_wdata | input | 32 | Write word for the current beat |
| cpu_rdy | output | 1 | One pulse per word transferred |
| cpu_rdata | output | 32 | Read word, valid with `cpu_rdy` |
| mem_req | output | 1 | Memory burst request |
| mem_we | output | 1 | Memory burst direction, 1 = write |
| mem_addr | output | 32 | Byte address of the current memory word |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | Memory accepted or returned one word |
| mem_rdata | input | 32 | Memory read word |

## Verification
The bench keeps the same line index while it changes tags. A controller that compares the wrong bits would return stale data on a hit, and one that allocates on a write miss would make the older line stop hitting. A dirty eviction is followed by a re-read of the evicted address. This exposes a missing write-back, a write-back to the new address instead of the old one, or a `cpu_rdy` raised during the write-back. Bit 17 is exercised in both modes, so a range check that ignores the halved write-back range would cache an address it must pass through. Irregular acknowledge gaps on the memory side catch a controller that counts cycles instead of acks.

// File: rtl/l2_wb_ctrl.sv
module l2_wb_ctrl #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wb_mode,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:4] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_rdy,
  output logic [31:0] cpu_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int LINES   = 1 << IDX_W;
  localparam int TAG_LSB = 4 + IDX_W;
  localparam int TOP     = TAG_LSB + TAG_W;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_HIT, S_EVICT, S_FILL, S_WTHRU} state_t;

  state_t            state;
  logic [31:4]       a_q;
  logic              we_q, upd_q, vld_q;
  logic [1:0]        beat, rd_beat;
  logic [TAG_W-1:0]  tag_q;
  logic [31:0]       dq;
  logic [TAG_W-1:0]  tag_mem [LINES];
  logic [31:0]       data_mem [LINES*4];
  logic [LINES-1:0]  valid;

  wire [IDX_W-1:0] idx = (state == S_IDLE) ? cpu_addr[TAG_LSB-1:4] : a_q[TAG_LSB-1:4];
  wire [TAG_W-1:0] atag = a_q[TOP-1:TAG_LSB];
  wire cacheable = (a_q[31:TOP] == '0) && !(wb_mode && a_q[TOP-1]);
  wire dirty     = wb_mode && tag_q[TAG_W-1];
  wire tag_eq    = wb_mode ? (tag_q[TAG_W-2:0] == atag[TAG_W-2:0]) : (tag_q == atag);
  wire hit       = cacheable && vld_q && tag_eq;
  wire last      = (beat == 2'd3);
  wire look      = (state == S_LOOK);
  wire rd_hit    = hit && !we_q;
  wire wb_hit    = hit && we_q && wb_mode;
  wire memio     = (state == S_FILL) || (state == S_WTHRU);

  wire dwr = (look && wb_hit) || (state == S_HIT && we_q) || (mem_ack && upd_q && memio);
  wire [31:0] dwd = (state == S_FILL) ? mem_rdata : cpu_wdata;

  always_comb begin
    case (state)
      S_LOOK:  rd_beat = rd_hit ? 2'd1 : 2'd0;
      S_HIT:   rd_beat = beat + 2'd1;
      S_EVICT: rd_beat = mem_ack ? beat + 2'd1 : beat;
      default: rd_beat = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    dq    <= data_mem[{idx, rd_beat}];
    tag_q <= tag_mem[idx];
    if (dwr) data_mem[{idx, beat}] <= dwd;
    if (look && wb_hit) tag_mem[idx] <= {1'b1, tag_q[TAG_W-2:0]};
    else if (state == S_FILL && upd_q && mem_ack && last) tag_mem[idx] <= atag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      a_q   <= '0;
      we_q  <= 1'b0;
      upd_q <= 1'b0;
      beat  <= 2'd0;
      valid <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid[idx];
      case (state)
        S_IDLE: if (cpu_req) begin
          state <= S_LOOK;
          a_q   <= cpu_addr;
          we_q  <= cpu_we;
          beat  <= 2'd0;
        end
        S_LOOK: begin
          upd_q <= we_q ? hit : cacheable;
          if (rd_hit || wb_hit) begin
            state <= S_HIT;
            beat  <= 2'd1;
          end else if (we_q)                       state <= S_WTHRU;
          else if (cacheable && vld_q && dirty)    state <= S_EVICT;
          else                                     state <= S_FILL;
        end
        S_HIT: begin
          beat <= beat + 2'd1;
          if (last) state <= S_IDLE;
        end
        S_EVICT: if (mem_ack) begin
          beat <= beat + 2'd1;
          if (last) state <= S_FILL;
        end
        S_FILL, S_WTHRU: if (mem_ack) begin
          beat <= beat + 2'd1;
          if (last) begin
            state <= S_IDLE;
            if (state == S_FILL && upd_q) valid[idx] <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cpu_rdy   = (look && (rd_hit || wb_hit)) || (state == S_HIT) || (mem_ack && memio);
  assign cpu_rdata = (state == S_FILL) ? mem_rdata : dq;
  assign mem_req   = (state == S_EVICT) || memio;
  assign mem_we    = (state == S_EVICT) || (state == S_WTHRU);
  assign mem_wdata = (state == S_EVICT) ? dq : cpu_wdata;
  assign mem_addr  = (state == S_EVICT)
                   ? {{(32-TOP){1'b0}}, 1'b0, tag_q[TAG_W-2:0], a_q[TAG_LSB-1:4], beat, 2'b00}
                   : {a_q, beat, 2'b00};
endmodule

// File: rtl/l2_wb_ctrl_chk.sv
module l2_wb_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  st,
  input logic        hit,
  input logic        we_q,
  input logic        wb_mode,
  input logic        cacheable,
  input logic [1:0]  beat,
  input logic        cpu_rdy,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr
);
  localparam logic [2:0] LOOK  = 3'd1;
  localparam logic [2:0] EVICT = 3'd3;

  a_r2_hit_next_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOOK && hit && !we_q) |=> (cpu_rdy && !mem_req));

  a_r6_wb_write_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOOK && hit && we_q && wb_mode) |=> !mem_req);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr));

  a_r3_rdy_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy && mem_req) |-> mem_ack);

  a_r7_fill_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EVICT && mem_ack && beat == 2'd3) |=> (mem_req && !mem_we));

  a_r8_outside_to_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOOK && !cacheable) |=> mem_req);
endmodule

bind l2_wb_ctrl l2_wb_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .hit(hit), .we_q(we_q), .wb_mode(wb_mode),
  .cacheable(cacheable), .beat(beat), .cpu_rdy(cpu_rdy), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/l2_wb_ctrl_test.sv
module l2_wb_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0, wb_mode = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:4] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rdy, mem_req, mem_we;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0, wcnt = 0;
  bit done = 0;

  logic [31:0] mm [int unsigned];
  logic [31:0] xm [int unsigned];
  bit          mv [64];
  int unsigned mt [64];
  bit          md [64];
  logic [31:0] mdat [64][4];

  l2_wb_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] init_word(int unsigned k);
    return k ^ 32'h5A5A_0000;
  endfunction

  always @(negedge clk) begin
    if (mem_req) begin
      wcnt++;
      mem_ack = (wcnt % 3) != 1;
    end else mem_ack = 1'b0;
    mem_rdata = mm.exists(mem_addr) ? mm[mem_addr] : init_word(mem_addr);
  end

  always @(posedge clk) if (mem_req && mem_ack && mem_we) mm[mem_addr] = mem_wdata;

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] xrd(int unsigned k);
    return xm.exists(k) ? xm[k] : init_word(k);
  endfunction

  task automatic do_reset(bit m);
    rst_n = 1'b0;
    wb_mode = m;
    for (int i = 0; i < 64; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!cpu_rdy, "R1", "cpu_rdy after reset", 32'(cpu_rdy), 0);
    chk(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic access(logic [31:0] a, bit we, logic [31:0] seed, string rq);
    int unsigned ix, tg, line;
    bit cach, hit, fast;
    logic [31:0] w [4];
    logic [31:0] exp_rd [4];
    logic [31:0] ewa [$];
    logic [31:0] ewd [$];
    int nb, nr, cyc;
    ix   = (a >> 4) & 63;
    tg   = (a >> 10) & 255;
    line = a & 32'hFFFF_FFF0;
    cach = ((a >> 18) == 0) && !(wb_mode && a[17]);
    hit  = cach && mv[ix] && (mt[ix] == tg);
    for (int b = 0; b < 4; b++) w[b] = seed + b * 32'h1111_1111;
    if (!we) begin
      if (hit) for (int b = 0; b < 4; b++) exp_rd[b] = mdat[ix][b];
      else begin
        if (cach && wb_mode && mv[ix] && md[ix])
          for (int b = 0; b < 4; b++) begin
            ewa.push_back((mt[ix] << 10) | (ix << 4) | (b << 2));
            ewd.push_back(mdat[ix][b]);
            xm[(mt[ix] << 10) | (ix << 4) | (b << 2)] = mdat[ix][b];
          end
        for (int b = 0; b < 4; b++) exp_rd[b] = xrd(line + b * 4);
        if (cach) begin
          mv[ix] = 1; mt[ix] = tg; md[ix] = 0;
          for (int b = 0; b < 4; b++) mdat[ix][b] = exp_rd[b];
        end
      end
    end else begin
      if (hit && wb_mode) begin
        md[ix] = 1;
        for (int b = 0; b < 4; b++) mdat[ix][b] = w[b];
      end else begin
        for (int b = 0; b < 4; b++) begin
          ewa.push_back(line + b * 4);
          ewd.push_back(w[b]);
          xm[line + b * 4] = w[b];
          if (hit) mdat[ix][b] = w[b];
        end
      end
    end
    fast = hit && (!we || wb_mode);

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a[31:4]; cpu_wdata = w[0];
    nb = 0; nr = 0; cyc = 0;
    while (nb < 4 && cyc < 200) begin
      #2;
      if (fast) begin
        chk(cpu_rdy == (cyc >= 1 && cyc <= 4), rq, "hit ready timing", 32'(cpu_rdy), 32'(cyc >= 1 && cyc <= 4));
        chk(!mem_req, rq, "no memory traffic on hit", 32'(mem_req), 0);
      end else begin
        if (cpu_rdy && !mem_ack) chk(0, rq, "ready without memory ack", 32'(cpu_rdy), 0);
        if (!we && cpu_rdy && mem_we) chk(0, "R7", "ready during write-back", 32'(cpu_rdy), 0);
      end
      if (mem_req && mem_ack && mem_we) begin
        if (ewa.size() == 0) chk(0, rq, "unexpected memory write", mem_addr, 0);
        else begin
          chk(mem_addr == ewa[0], rq, "memory write address (R10)", mem_addr, ewa[0]);
          chk(mem_wdata == ewd[0], rq, "memory write data", mem_wdata, ewd[0]);
          void'(ewa.pop_front());
          void'(ewd.pop_front());
        end
      end
      if (mem_req && mem_ack && !mem_we) begin
        chk(!we && ewa.size() == 0, rq, "memory read order", 32'(ewa.size()), 0);
        chk(mem_addr == line + nr * 4, "R10", "memory read address", mem_addr, line + nr * 4);
        nr++;
      end
      if (cpu_rdy) begin
        if (!we) chk(cpu_rdata == exp_rd[nb], rq, "read word", cpu_rdata, exp_rd[nb]);
        nb++;
      end
      @(negedge clk);
      cyc++;
      if (nb < 4) cpu_wdata = w[nb];
    end
    chk(nb == 4, rq, "burst completed", 32'(nb), 4);
    chk(ewa.size() == 0, rq, "all expected memory writes seen", 32'(ewa.size()), 0);
    if (!we && !hit) chk(nr == 4, rq, "memory reads in miss", 32'(nr), 4);
    cpu_req = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // write-through session
    do_reset(0);
    access(32'h0000_0100, 0, 0, "R1 R3 first read misses");
    access(32'h0000_0100, 0, 0, "R2 read hit");
    access(32'h0000_0100, 1, 32'hA000_0001, "R4 write-through hit");
    access(32'h0000_0100, 0, 0, "R4 R2 hit sees new data");
    access(32'h0000_0500, 1, 32'hB000_0002, "R5 write miss bypass");
    access(32'h0000_0100, 0, 0, "R5 old line unchanged");
    access(32'h0000_0500, 0, 0, "R9 R3 conflict miss");
    access(32'h0000_0500, 0, 0, "R2 R9 refilled line hits");
    access(32'h0004_0100, 0, 0, "R8 above range misses");
    access(32'h0004_0100, 0, 0, "R8 above range not allocated");
    access(32'h0002_0100, 0, 0, "R8 bit17 cacheable in write-through");
    access(32'h0002_0100, 0, 0, "R8 R2 bit17 line hits");
    access(32'h0000_3FF0, 0, 0, "R9 top index miss");
    access(32'h0000_3FF0, 0, 0, "R2 top index hit");
    // write-back session
    do_reset(1);
    access(32'h0000_0100, 0, 0, "R1 lines invalid after reset");
    access(32'h0000_0100, 1, 32'hC000_0003, "R6 write-back hit");
    access(32'h0000_0100, 0, 0, "R6 hit returns dirty data");
    access(32'h0000_0500, 0, 0, "R7 dirty read miss writes back");
    access(32'h0000_0100, 0, 0, "R7 evicted data reached memory");
    access(32'h0000_0100, 1, 32'hD000_0004, "R6 write-back hit again");
    access(32'h0000_0500, 1, 32'hE000_0005, "R5 write miss on dirty index");
    access(32'h0000_0100, 0, 0, "R5 dirty line kept");
    access(32'h0002_0100, 0, 0, "R8 bit17 outside write-back range");
    access(32'h0002_0100, 0, 0, "R8 bit17 still misses");
    access(32'h0000_0200, 0, 0, "R3 second index fill");
    access(32'h0000_0200, 1, 32'hF000_0006, "R6 dirty second index");
    access(32'h0000_0600, 0, 0, "R7 second dirty eviction");
    access(32'h0000_0500, 0, 0, "R7 first index evicts dirty line");
    access(32'h0000_0200, 0, 0, "R7 second evicted data in memory");
    done = 1;
    summary();
    $finish;
  end
endmodule